// File: doc/BRIEF.md
# Down-Counting Timer with Edge-Synchronized Run Control

This block is an 8-bit programmable down-counter for a small microcontroller. It steps on falling edges of a selected counting source. That source is either a prescaled timing clock or an external event line. Both inputs are asynchronous. Each one passes through a synchronizer into the system clock domain, and its falling edges become single-cycle step enables, so all state sits in one clock domain.

The CPU writes a control word (run request, output enable, event mode) and a reload value. It reads back the live count, the reload value and the actual run state. A run or stop request does not act at once. It waits for the next falling edge of the counting source. A stop still allows one final decrement on that edge, and the run flag in the readback stays at 1 until the counter has actually halted.

When the count steps below zero, the counter reloads from the reload register and emits a one-cycle underflow pulse. A timer output toggles on each underflow while output enable is set. A plain gate forces it low while output enable is clear. That gate is not tied to the counting clock, so a glitch shorter than half a cycle can appear when it switches.

Top module: `pgm_down_timer`

## Requirements
- R1: After reset the counter is stopped, the count and reload value read 0x00, output enable and event mode read 0, and `tmr_out` and `uflow_pulse` are low.
- R2: After a write that sets the run bit, the run flag reads 0 until the next falling edge of the counting source. On that edge the counter starts without decrementing. Each later falling edge decrements it by one.
- R3: After a write that clears the run bit, the run flag keeps reading 1. On the next falling edge of the counting source the counter decrements once more, the run flag drops to 0, and the count then holds.
- R4: While no falling edge of the selected counting source arrives, the run state never changes, however long a pending request has been waiting.
- R5: With event mode set (control bit 2), the counter steps only on falling edges of `evt_in`, and edges on `cnt_clk_in` have no effect. With event mode clear, it steps only on falling edges of `cnt_clk_in`.
- R6: A step taken at count 0x00 loads the reload value instead of decrementing. The step that loads the reload value drives `uflow_pulse` high for exactly one system clock cycle.
- R7: While output enable (control bit 1) is set, `tmr_out` toggles on each underflow, starting low. While output enable is clear, `tmr_out` is low and underflows do not change it.
- R8: A write to the reload register while the counter is stopped also loads the count. While the counter is running, such a write changes only the reload register.
- R9: Address map. Address 0 is control: write bit 0 = run request, bit 1 = output enable, bit 2 = event mode; read bit 0 = actual run state, bit 1 = output enable, bit 2 = event mode. Address 1 is the reload value (read/write). Address 2 reads the count. Address 3 reads 0.
- R10: Each falling edge of the counting source, once synchronized, yields exactly one single-cycle step enable, so one edge moves the count by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clk_in | input | 1 | Prescaled counting clock, asynchronous |
| evt_in | input | 1 | External event input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| uflow_pulse | output | 1 | One-cycle underflow pulse |
| tmr_out | output | 1 | Toggled timer output, gated by output enable |

## Verification
A stop request and an underflow can land on the same counting edge. The bench lets the count reach 0x00 in event mode, clears the run bit, and then sends one event edge. It expects the count to hold the reload value, the run flag to read 0, and exactly one underflow pulse. A second edge must leave the count unchanged. The bench also issues reload writes while the counter is running, interleaved with steps, and checks that the count ignores them.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_SPARE  = 2'd3
  } pdt_reg_e;

  localparam int CTL_RUN = 0;
  localparam int CTL_OE  = 1;
  localparam int CTL_EVT = 2;
  localparam int N_SRC   = 2;
  localparam int SRC_CLK = 0;
  localparam int SRC_EVT = 1;
endpackage

// File: rtl/pdt_fall_det.sv
module pdt_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LEN-2:0], async_in};
  end

  assign fall = sh_q[LEN-1] & ~sh_q[LEN-2];

  // R10
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/pdt_core.sv
module pdt_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run_req,
  input  logic         rld_wr,
  input  logic [W-1:0] rld_data,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         run_q,
  output logic         uf_evt,
  output logic         uf_pulse
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic step;
  assign step   = tick & run_q;
  assign uf_evt = step & (cnt_q == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else if (tick) run_q <= run_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rld_q <= ZERO;
    else if (rld_wr) rld_q <= rld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else if (step) cnt_q <= (cnt_q == ZERO) ? rld_q : cnt_q - ONE;
    else if (rld_wr && !run_q) cnt_q <= rld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_pulse <= 1'b0;
    else        uf_pulse <= uf_evt;
  end

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !rld_wr) |=> $stable(cnt_q));
  // R4
  run_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(run_q));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && cnt_q == ZERO) |=> (cnt_q == $past(rld_q)) && uf_pulse);
  // R6
  uflow_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_pulse |=> !uf_pulse);
endmodule

// File: rtl/pdt_tout.sv
module pdt_tout (
  input  logic clk,
  input  logic rst_n,
  input  logic oe,
  input  logic uf_evt,
  output logic tmr_out
);
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (!oe)    tog_q <= 1'b0;
    else if (uf_evt) tog_q <= ~tog_q;
  end

  assign tmr_out = tog_q & oe;

  // R7
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && uf_evt) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/pgm_down_timer.sv
module pgm_down_timer
  import pdt_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_clk_in,
  input  logic         evt_in,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         uflow_pulse,
  output logic         tmr_out
);
  logic [N_SRC-1:0] src_raw;
  logic [N_SRC-1:0] src_fall;
  logic run_req_q, oe_q, evt_q;
  logic tick, ctrl_wr, rld_wr;
  logic [W-1:0] cnt, rld;
  logic run_q, uf_evt;

  assign src_raw[SRC_CLK] = cnt_clk_in;
  assign src_raw[SRC_EVT] = evt_in;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    pdt_fall_det #(.STAGES(SYNC_STAGES)) u_fd (
      .clk(clk), .rst_n(rst_n), .async_in(src_raw[g]), .fall(src_fall[g])
    );
  end

  assign tick    = evt_q ? src_fall[SRC_EVT] : src_fall[SRC_CLK];
  assign ctrl_wr = wr_en && (pdt_reg_e'(wr_addr) == REG_CTRL);
  assign rld_wr  = wr_en && (pdt_reg_e'(wr_addr) == REG_RELOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req_q <= 1'b0;
      oe_q      <= 1'b0;
      evt_q     <= 1'b0;
    end else if (ctrl_wr) begin
      run_req_q <= wr_data[CTL_RUN];
      oe_q      <= wr_data[CTL_OE];
      evt_q     <= wr_data[CTL_EVT];
    end
  end

  pdt_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_req(run_req_q),
    .rld_wr(rld_wr), .rld_data(wr_data), .cnt_q(cnt), .rld_q(rld),
    .run_q(run_q), .uf_evt(uf_evt), .uf_pulse(uflow_pulse)
  );

  pdt_tout u_tout (
    .clk(clk), .rst_n(rst_n), .oe(oe_q), .uf_evt(uf_evt), .tmr_out(tmr_out)
  );

  always_comb begin
    rd_data = '0;
    case (pdt_reg_e'(rd_addr))
      REG_CTRL: begin
        rd_data[CTL_RUN] = run_q;
        rd_data[CTL_OE]  = oe_q;
        rd_data[CTL_EVT] = evt_q;
      end
      REG_RELOAD: rd_data = rld;
      REG_COUNT:  rd_data = cnt;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: tb/pgm_down_timer_bench.sv
module pgm_down_timer_bench;
  logic clk = 0, rst_n = 0, cnt_clk_in = 0, evt_in = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic uflow_pulse, tmr_out;
  int total = 0, bad = 0, uf_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pgm_down_timer u_pgm_down_timer (
    .clk(clk), .rst_n(rst_n), .cnt_clk_in(cnt_clk_in), .evt_in(evt_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .uflow_pulse(uflow_pulse), .tmr_out(tmr_out)
  );

  always @(negedge clk) if (rst_n && uflow_pulse) uf_seen++;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, input logic [1:0] a, int exp);
    @(negedge clk); rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic clk_fall();
    @(negedge clk); cnt_clk_in = 1; repeat (4) @(negedge clk);
    cnt_clk_in = 0; repeat (5) @(negedge clk);
  endtask

  task automatic evt_fall();
    @(negedge clk); evt_in = 1; repeat (4) @(negedge clk);
    evt_in = 0; repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 0, 0);
    rd_chk("R1 reload", 1, 0);
    rd_chk("R1 count", 2, 0);
    chk("R1 tmr_out", tmr_out, 0);
    chk("R1 uflow", uflow_pulse, 0);
    rd_chk("R9 spare", 3, 0);
  endtask

  task automatic t_start();
    wr(1, 8'h42);
    rd_chk("R8 stopped load", 2, 8'h42);
    wr(0, 8'h01);
    rd_chk("R2 pending start", 0, 0);
    repeat (20) @(negedge clk);
    rd_chk("R4 no edge start", 0, 0);
    clk_fall();
    rd_chk("R2 started", 0, 1);
    rd_chk("R2 no dec on start", 2, 8'h42);
    clk_fall();
    rd_chk("R2 dec1", 2, 8'h41);
    clk_fall();
    rd_chk("R2 dec2", 2, 8'h40);
  endtask

  task automatic t_stop();
    wr(0, 8'h00);
    rd_chk("R3 flag held", 0, 1);
    repeat (10) @(negedge clk);
    rd_chk("R4 no edge stop", 0, 1);
    rd_chk("R3 count before edge", 2, 8'h40);
    clk_fall();
    rd_chk("R3 stopped", 0, 0);
    rd_chk("R3 last dec", 2, 8'h3F);
    clk_fall();
    rd_chk("R3 hold", 2, 8'h3F);
  endtask

  task automatic t_reload_running();
    wr(0, 8'h01);
    clk_fall();
    wr(1, 8'h05);
    rd_chk("R8 running no load", 2, 8'h3F);
    rd_chk("R8 reload reg", 1, 8'h05);
    clk_fall();
    rd_chk("R8 dec after write", 2, 8'h3E);
  endtask

  task automatic t_underflow();
    int base;
    wr(0, 8'h00);
    clk_fall();
    wr(1, 8'h02);
    wr(0, 8'h03);
    rd_chk("R9 ctrl readback", 0, 8'h02);
    clk_fall();
    rd_chk("R9 ctrl running", 0, 8'h03);
    base = uf_seen;
    clk_fall(); clk_fall();
    rd_chk("R6 at zero", 2, 0);
    chk("R7 low before uflow", tmr_out, 0);
    clk_fall();
    rd_chk("R6 reload", 2, 2);
    chk("R6 one-cycle pulse", uf_seen - base, 1);
    chk("R7 toggle high", tmr_out, 1);
    clk_fall(); clk_fall(); clk_fall();
    chk("R6 second pulse", uf_seen - base, 2);
    chk("R7 toggle low", tmr_out, 0);
    clk_fall(); clk_fall(); clk_fall();
    chk("R7 toggle high again", tmr_out, 1);
    wr(0, 8'h01);
    chk("R7 gated low", tmr_out, 0);
    clk_fall(); clk_fall(); clk_fall();
    chk("R7 disabled uflow", tmr_out, 0);
    chk("R6 pulse while disabled", uf_seen - base, 4);
  endtask

  task automatic t_event();
    int base;
    wr(0, 8'h00);
    clk_fall();
    wr(0, 8'h04);
    wr(1, 8'h03);
    wr(0, 8'h05);
    clk_fall();
    rd_chk("R5 clock ignored", 0, 8'h04);
    evt_fall();
    rd_chk("R5 event start", 0, 8'h05);
    evt_fall();
    rd_chk("R5 event dec", 2, 2);
    clk_fall();
    rd_chk("R5 clock no dec", 2, 2);
    evt_fall(); evt_fall();
    rd_chk("R6 event zero", 2, 0);
    base = uf_seen;
    wr(0, 8'h04);
    evt_fall();
    rd_chk("R3 stop on uflow flag", 0, 8'h04);
    rd_chk("R6 stop on uflow reload", 2, 3);
    chk("R6 stop on uflow pulse", uf_seen - base, 1);
    evt_fall();
    rd_chk("R3 hold after uflow stop", 2, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_start();
    t_stop();
    t_reload_running();
    t_underflow();
    t_event();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule